// File: doc/BRIEF.md
# Interval Timer with Single-Shot Mode

This block is a memory-mapped up-counting timer that serves as a tick and event source. A prescaler divides the input clock, and each divided tick advances a main counter. When the counter has reached the active reload value and another tick arrives, the counter returns to zero. That return is an update event. Update events raise a sticky flag, and an enabled flag drives a level interrupt.

The timer runs in one of two modes. In repeating mode it keeps cycling. In single-shot mode it produces one update event and then turns its own run bit off. Software can also force an update event. A forced update restarts both counts and loads the buffered prescaler and reload values.

The reload value can be written straight through to the compare, or held in a buffer until the next update event. A parameter sets the counter and reload width to 16 or 32 bits. Software can find the width by writing all ones to the reload register and reading it back.

Top module: `tick_timer`

## Requirements
- R1: After reset, every register reads 0 and `irq` is 0.
- R2: Registers sit at byte offsets 0x00 control, 0x0C interrupt enable, 0x10 status, 0x14 event, 0x28 prescaler and 0x2C reload. Control stores only bit 0 (run), bit 3 (single-shot) and bit 7 (reload buffering), and reads its other bits as 0. The event register and all unused offsets read 0.
- R3: The reload register keeps only its implemented low bits. On a 16-bit instance, writing 0xFFFFFFFF reads back 0x0000FFFF. The prescaler register keeps its low DIV_W bits.
- R4: With active prescaler P and active reload A, the first update event comes (P+1)(A+1) clocks after the clock edge that set the run bit from a zero count. That event sets status bit 0.
- R5: In repeating mode, update events recur every (P+1)(A+1) clocks.
- R6: Writing a control value with bit 0 clear stops counting from that edge, and both counts hold their values. Setting bit 0 again resumes from the held count.
- R7: With single-shot mode on, the first overflow update clears control bit 0, and no further update events follow.
- R8: With bit 7 clear, a reload write takes part in the very next compare. With bit 7 set, the compare keeps the old value until the next update event. Reload readback always shows the last written value.
- R9: A prescaler write takes effect only at the next update event. Until then, the running period keeps the old division.
- R10: Writing 1 to event bit 0 forces an update event. It clears both counts, loads the buffered prescaler and reload, and sets the status flag. Writing 0 there has no effect.
- R11: Writing 0 to status bit 0 clears the flag, and writing 1 leaves it unchanged. If an update event and a clearing write fall on the same edge, the flag stays set.
- R12: `irq` equals status bit 0 ANDed with interrupt-enable bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq | output | 1 | Level update interrupt |

## Verification
All internal count state is hidden behind the register bus. A wrong prescaler count, main count or active reload therefore appears as a status flag, or `irq`, that rises one or more clocks early or late. The bench polls the flag on the clock before the expected event and on the clock of the event, so an error of a single clock is caught within one period. A buffering fault changes the length of the first period after a write. A single-shot fault appears as a control read that still shows the run bit, or as a flag that comes back after it has been cleared.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_IEN  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_STAT = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_EVG  = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_DIV  = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_RLD  = 8'h2C;

    localparam int CTL_RUN  = 0;
    localparam int CTL_ONCE = 3;
    localparam int CTL_BUF  = 7;

    typedef struct packed {
        logic buf_en;
        logic once;
        logic run;
    } ctl_t;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [31:0]       data;
    } bus_req_t;

    function automatic logic [31:0] ctl_to_word(ctl_t c);
        logic [31:0] w;
        w = '0;
        w[CTL_RUN]  = c.run;
        w[CTL_ONCE] = c.once;
        w[CTL_BUF]  = c.buf_en;
        return w;
    endfunction

    function automatic ctl_t word_to_ctl(logic [31:0] w);
        ctl_t c;
        c.run    = w[CTL_RUN];
        c.once   = w[CTL_ONCE];
        c.buf_en = w[CTL_BUF];
        return c;
    endfunction
endpackage

// File: rtl/tmr_regfile.sv
module tmr_regfile
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_req_t         req,
    input  logic             ovf,
    output logic [31:0]      rdata,
    output ctl_t             ctl,
    output logic             ien,
    output logic             flag,
    output logic             force_upd,
    output logic [DIV_W-1:0] div_pre,
    output logic [CNT_W-1:0] rld_pre
);
    logic wr_ctl, wr_ien, wr_stat, wr_evg, wr_div, wr_rld;
    logic stat_clr;

    assign wr_ctl    = req.wr && (req.addr == OFS_CTRL);
    assign wr_ien    = req.wr && (req.addr == OFS_IEN);
    assign wr_stat   = req.wr && (req.addr == OFS_STAT);
    assign wr_evg    = req.wr && (req.addr == OFS_EVG);
    assign wr_div    = req.wr && (req.addr == OFS_DIV);
    assign wr_rld    = req.wr && (req.addr == OFS_RLD);
    assign stat_clr  = wr_stat && !req.data[0];
    assign force_upd = wr_evg && req.data[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl     <= '0;
            ien     <= 1'b0;
            flag    <= 1'b0;
            div_pre <= '0;
            rld_pre <= '0;
        end else begin
            if (wr_ctl) begin
                ctl <= word_to_ctl(req.data);
            end else if (ovf && ctl.once) begin
                ctl.run <= 1'b0;
            end
            if (wr_ien) ien <= req.data[0];
            if (ovf || force_upd) begin
                flag <= 1'b1;
            end else if (stat_clr) begin
                flag <= 1'b0;
            end
            if (wr_div) div_pre <= req.data[DIV_W-1:0];
            if (wr_rld) rld_pre <= req.data[CNT_W-1:0];
        end
    end

    always_comb begin
        unique case (req.addr)
            OFS_CTRL: rdata = ctl_to_word(ctl);
            OFS_IEN:  rdata = {31'd0, ien};
            OFS_STAT: rdata = {31'd0, flag};
            OFS_DIV:  rdata = 32'(div_pre);
            OFS_RLD:  rdata = 32'(rld_pre);
            default:  rdata = '0;
        endcase
    end

    assert_once_stop_R7: assert property (@(posedge clk) disable iff (rst)
        (ovf && ctl.once && !wr_ctl) |=> !ctl.run);
    assert_flag_set_R11: assert property (@(posedge clk) disable iff (rst)
        (ovf || force_upd) |=> flag);
    assert_flag_keep_R11: assert property (@(posedge clk) disable iff (rst)
        (flag && !stat_clr) |=> flag);
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             upd,
    input  logic [DIV_W-1:0] div_pre,
    output logic             tick
);
    logic [DIV_W-1:0] div_act;
    logic [DIV_W-1:0] pcnt;

    assign tick = run && (pcnt == div_act);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_act <= '0;
            pcnt    <= '0;
        end else if (upd) begin
            div_act <= div_pre;
            pcnt    <= '0;
        end else if (run) begin
            pcnt <= tick ? '0 : pcnt + 1'b1;
        end
    end

    assert_tick_restart_R9: assert property (@(posedge clk) disable iff (rst)
        tick |=> (pcnt == '0));
    assert_div_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!run && !upd) |=> $stable(pcnt));
    assert_div_swap_R9: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(div_act));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             force_upd,
    input  logic             buf_en,
    input  logic [CNT_W-1:0] rld_pre,
    output logic             ovf
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] rld_shadow;
    logic [CNT_W-1:0] rld_eff;

    assign rld_eff = buf_en ? rld_shadow : rld_pre;
    assign ovf     = tick && (cnt == rld_eff);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt        <= '0;
            rld_shadow <= '0;
        end else begin
            if (force_upd || ovf) begin
                cnt <= '0;
            end else if (tick) begin
                cnt <= cnt + 1'b1;
            end
            if (force_upd || ovf || !buf_en) begin
                rld_shadow <= rld_pre;
            end
        end
    end

    assert_wrap_zero_R4: assert property (@(posedge clk) disable iff (rst)
        ovf |=> (cnt == '0));
    assert_count_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!tick && !force_upd) |=> $stable(cnt));
    assert_force_clear_R10: assert property (@(posedge clk) disable iff (rst)
        force_upd |=> (cnt == '0));
    assert_shadow_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (buf_en && !ovf && !force_upd) |=> $stable(rld_shadow));
endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tmr_pkg::*;
#(
    parameter bit WIDE_CNT = 1'b0,
    parameter int DIV_W    = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  bus_addr,
    input  logic        bus_we,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq
);
    localparam int CNT_W = WIDE_CNT ? 32 : 16;

    bus_req_t         req;
    ctl_t             ctl;
    logic             ien, flag, force_upd, ovf, tick, upd;
    logic [DIV_W-1:0] div_pre;
    logic [CNT_W-1:0] rld_pre;

    assign req = '{wr: bus_we, addr: bus_addr, data: bus_wdata};
    assign upd = ovf || force_upd;

    tmr_regfile #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .ovf       (ovf),
        .rdata     (bus_rdata),
        .ctl       (ctl),
        .ien       (ien),
        .flag      (flag),
        .force_upd (force_upd),
        .div_pre   (div_pre),
        .rld_pre   (rld_pre)
    );

    tmr_prescaler #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .run     (ctl.run),
        .upd     (upd),
        .div_pre (div_pre),
        .tick    (tick)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .force_upd (force_upd),
        .buf_en    (ctl.buf_en),
        .rld_pre   (rld_pre),
        .ovf       (ovf)
    );

    assign irq = flag && ien;

    assert_irq_gate_R12: assert property (@(posedge clk) disable iff (rst)
        !ien |-> !irq);
    assert_tick_needs_run_R6: assert property (@(posedge clk) disable iff (rst)
        tick |-> ctl.run);
endmodule

// File: tb/tick_timer_test.sv
module tick_timer_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  a   = '0;
    logic        we  = 1'b0;
    logic [31:0] wd  = '0;
    logic [31:0] rd;
    logic        irq;

    localparam logic [7:0] A_CTRL = 8'h00, A_IEN = 8'h0C, A_STAT = 8'h10,
                           A_EVG = 8'h14, A_DIV = 8'h28, A_RLD = 8'h2C;

    always #4 clk = ~clk;

    tick_timer #(.WIDE_CNT(1'b0), .DIV_W(16)) uut (
        .clk(clk), .rst(rst), .bus_addr(a), .bus_we(we),
        .bus_wdata(wd), .bus_rdata(rd), .irq(irq)
    );

    int ncyc = 0;
    always @(posedge clk) ncyc <= ncyc + 1;

    logic [31:0] exp_q[$];
    logic [31:0] act_q[$];
    string       tag_q[$];
    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always @(negedge clk) begin : monitor
        logic [31:0] e, g;
        string t;
        while (act_q.size() > 0) begin
            e = exp_q.pop_front();
            g = act_q.pop_front();
            t = tag_q.pop_front();
            n_cmp++;
            if (e !== g) begin
                n_bad++;
                $display("FAIL %s: actual %h expected %h", t, g, e);
            end
        end
    end

    task automatic wr(input logic [7:0] ad, input logic [31:0] d);
        a = ad; wd = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic chk(input logic [7:0] ad, input logic [31:0] e, input string t);
        a = ad;
        #1;
        exp_q.push_back(e); act_q.push_back(rd); tag_q.push_back(t);
    endtask

    task automatic chk_irq(input logic e, input string t);
        #1;
        exp_q.push_back({31'd0, e}); act_q.push_back({31'd0, irq}); tag_q.push_back(t);
    endtask

    task automatic wait_until(input int t);
        while (ncyc < t) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : driver
        int t0, es, er, ov2, eg, t1, t2, t3, t4;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state, R2 read-only and unused offsets
        chk(A_CTRL, 0, "R1 ctrl"); chk(A_IEN, 0, "R1 ien"); chk(A_STAT, 0, "R1 stat");
        chk(A_EVG, 0, "R1 evg"); chk(A_DIV, 0, "R1 div"); chk(A_RLD, 0, "R1 rld");
        chk_irq(1'b0, "R1 irq");
        chk(8'h04, 0, "R2 unused 04"); chk(8'h30, 0, "R2 unused 30");

        // R3 width detection
        wr(A_RLD, 32'hFFFF_FFFF); chk(A_RLD, 32'h0000_FFFF, "R3 reload width");
        wr(A_DIV, 32'hFFFF_FFFF); chk(A_DIV, 32'h0000_FFFF, "R3 divider width");
        // R2 control bit storage
        wr(A_CTRL, 32'h88); chk(A_CTRL, 32'h88, "R2 ctrl bits");
        wr(A_CTRL, 32'hFFFF_FF76); chk(A_CTRL, 0, "R2 ctrl other bits");
        wr(A_EVG, 32'h0); chk(A_EVG, 0, "R2 evg reads zero");

        // R10 forced load, R11 clear, R4 first period (P=2, A=3 -> 12)
        wr(A_DIV, 2); wr(A_RLD, 3); wr(A_EVG, 1);
        chk(A_STAT, 1, "R10 forced update sets flag");
        wr(A_STAT, 0); chk(A_STAT, 0, "R11 write zero clears");
        wr(A_IEN, 1); wr(A_CTRL, 1); t0 = ncyc;
        wait_until(t0 + 11); chk(A_STAT, 0, "R4 before period"); chk_irq(1'b0, "R12 irq low");
        wait_until(t0 + 12); chk(A_STAT, 1, "R4 at period"); chk_irq(1'b1, "R12 irq high");
        wr(A_STAT, 1); chk(A_STAT, 1, "R11 write one no effect");
        wr(A_STAT, 0); chk(A_STAT, 0, "R11 clear");
        wait_until(t0 + 23); chk(A_STAT, 0, "R5 before second");
        wait_until(t0 + 24); chk(A_STAT, 1, "R5 second period");
        wr(A_IEN, 0); chk(A_STAT, 1, "R12 flag held"); chk_irq(1'b0, "R12 gated by enable");
        wr(A_STAT, 0);

        // R6 stop and resume: 5 counted edges before stop
        wait_until(t0 + 28); wr(A_CTRL, 0); es = ncyc;
        chk(A_CTRL, 0, "R6 ctrl cleared");
        wait_until(es + 20); chk(A_STAT, 0, "R6 frozen no event");
        wr(A_CTRL, 1); er = ncyc;
        wait_until(er + 6); chk(A_STAT, 0, "R6 resume early");
        wait_until(er + 7); chk(A_STAT, 1, "R6 resume from held count");
        ov2 = er + 7;

        // R10 forced restart mid-period
        wr(A_STAT, 0);
        wait_until(ov2 + 4); wr(A_EVG, 1); eg = ncyc;
        chk(A_STAT, 1, "R10 force sets flag while running");
        wr(A_STAT, 0);
        wait_until(eg + 11); chk(A_STAT, 0, "R10 restart early");
        wait_until(eg + 12); chk(A_STAT, 1, "R10 restart period");
        wr(A_STAT, 0); wr(A_EVG, 0); chk(A_STAT, 0, "R10 write zero no event");
        wait_until(eg + 23); chk(A_STAT, 0, "R10 zero write kept count");
        wait_until(eg + 24); chk(A_STAT, 1, "R10 period unchanged");

        // R8 buffered reload, R9 buffered divider
        wr(A_CTRL, 0); wr(A_CTRL, 32'h80); wr(A_EVG, 1); wr(A_STAT, 0);
        wr(A_CTRL, 32'h81); t1 = ncyc;
        wr(A_RLD, 7); wr(A_DIV, 0);
        chk(A_RLD, 7, "R8 readback of written reload");
        wait_until(t1 + 11); chk(A_STAT, 0, "R8 old reload held");
        wait_until(t1 + 12); chk(A_STAT, 1, "R9 old divider held");
        wr(A_STAT, 0);
        wait_until(t1 + 19); chk(A_STAT, 0, "R9 new values early");
        wait_until(t1 + 20); chk(A_STAT, 1, "R9 new divider and reload");

        // R8 unbuffered reload used at once
        wr(A_CTRL, 0); wr(A_EVG, 1); wr(A_STAT, 0);
        wr(A_CTRL, 1); t2 = ncyc;
        wr(A_RLD, 2);
        wait_until(t2 + 2); chk(A_STAT, 0, "R8 direct early");
        wait_until(t2 + 3); chk(A_STAT, 1, "R8 direct reload");

        // R7 single-shot (P=1, A=4 -> 10)
        wr(A_CTRL, 0); wr(A_RLD, 4); wr(A_DIV, 1); wr(A_EVG, 1); wr(A_STAT, 0);
        wr(A_CTRL, 9); t3 = ncyc;
        wait_until(t3 + 9); chk(A_STAT, 0, "R7 early"); chk(A_CTRL, 9, "R7 still running");
        wait_until(t3 + 10); chk(A_STAT, 1, "R7 event"); chk(A_CTRL, 8, "R7 run bit cleared");
        wr(A_STAT, 0);
        wait_until(t3 + 40); chk(A_STAT, 0, "R7 no further events");

        // R11 set wins over a clearing write on the same edge
        wr(A_DIV, 0); wr(A_RLD, 5); wr(A_EVG, 1); wr(A_STAT, 0);
        wr(A_CTRL, 1); t4 = ncyc;
        wait_until(t4 + 5); wr(A_STAT, 0);
        chk(A_STAT, 1, "R11 set beats clear");
        wr(A_CTRL, 0);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule